// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block is the transmit-side DMA for an Ethernet port. Software builds packets as 128-byte descriptors in a 64-entry ring in memory. It programs the ring base address and then moves a write index forward. The engine keeps its own read index. It fetches each pending descriptor, collects the packet bytes and sends them, one byte per beat, on a valid/ready stream towards a MAC. Once a packet is sent, it overwrites the first descriptor word with a completion pattern and raises status bits that drive an interrupt line.

Packet bytes come from two kinds of place. The first is an inline area inside the descriptor, which begins at a programmable offset. The second is up to three chained scatter buffers elsewhere in memory. Memory is reached through a simple master that issues one 64-bit read or write per request and waits for an acknowledge. Memory is big-endian: descriptor byte 0 is bits 63:56 of the word at the descriptor address.

Top module: `tx_ring_engine`

## Requirements
- R1: Descriptor i lies at ring base + i*128. After each descriptor is handled, the read index steps by one and wraps from 63 to 0. A memory request holds its address and direction until it is acknowledged.
- R2: The engine issues no memory request while the ring base register is zero. It stops fetching as soon as the read index equals the write index.
- R3: A descriptor whose byte 0 bit 7 is set is skipped. No byte is streamed and no write-back is done for it, but the read index still advances.
- R4: A descriptor whose bytes 6–7 read zero is empty. It is not sent, and the read index stays on it until software changes the descriptor.
- R5: Bytes 6–7 (big-endian) hold the packet length minus one. The stream first carries the inline bytes from the offset in byte 5 bits 6:0 through descriptor byte 127. After that come the scatter buffers. The stream carries exactly that many bytes, and tx_last is high on the final byte only.
- R6: Scatter pointer n (n = 1..3) lives in descriptor bytes 8n..8n+7 and is enabled by byte 4 bit n. Bytes 8n+2..8n+3 hold its length minus one. Bytes 8n+4..8n+7 hold its address, rounded down to a multiple of 8. The chain ends at the first disabled pointer. If the data runs out before the length is reached, the packet ends without tx_last and status bit 2 is set.
- R7: A length above 1700 bytes is cut to 1700 bytes, and status bit 2 is set.
- R8: On completion, descriptor word 0 becomes 80 00 00 00 00 80 followed by the original length bytes. Status bits 0 (ring drained) and 1 (packet sent) are set.
- R9: The register map is: index 0 ring base; index 1 ring pointers (read index in bits 21:16, read-only; write index in bits 5:0); index 2 status; index 3 control. A write to index 1 changes only the write index. All registers reset to zero.
- R10: Writing ones to status bits 7:0 clears those bits. A status bit that the engine sets in the same cycle stays set.
- R11: A write to the control register with bit 0 clear clears status bit 0. With bit 0 set, the write leaves status unchanged.
- R12: irq is the OR of status bits 7:0 and follows them one cycle later.
- R13: While tx_valid is high and tx_ready is low, tx_data and tx_last stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address; bits 2:0 are zero |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach is the ring wrap combined with an empty descriptor. The read index can only move forward, one descriptor at a time. To bring it from 4 around to 2, the bench first parks the engine on an empty descriptor, where it polls. It then marks entries 5 to 63 as already sent and rewrites entry 4 as a short scatter chain in the same step. Finally it moves the write index to 2, so the engine streams one partial packet and then skips its way through the wrap. Length truncation needs a descriptor of 2000 bytes whose inline area overlaps its own header. All of this runs under an irregular tx_ready pattern, so the streaming path is tested under backpressure.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int REG_BASE = 0;
  localparam int REG_PTR  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_CTRL = 3;

  localparam int ST_DRAINED = 0;
  localparam int ST_SENT    = 1;
  localparam int ST_LENERR  = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_PTR, S_FETCH, S_SEND, S_WB, S_ADV
  } dma_state_t;
endpackage

// File: rtl/tx_ring_regs.sv
module tx_ring_regs
  import tx_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              adv,
  input  logic [7:0]        set_bits,
  output logic [ADDR_W-1:0] base,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              irq
);
  logic [ADDR_W-1:0] base_q;
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [7:0]        status_q, status_d;
  logic [31:0]       rdata_q;
  logic              irq_q;

  always_comb begin
    status_d = status_q;
    if (reg_we && reg_addr == 2'(REG_STAT)) status_d = status_d & ~reg_wdata[7:0];
    if (reg_we && reg_addr == 2'(REG_CTRL) && !reg_wdata[0]) status_d[ST_DRAINED] = 1'b0;
    status_d = status_d | set_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      rd_q     <= '0;
      wr_q     <= '0;
      status_q <= '0;
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_q;
      if (adv) rd_q <= rd_q + 1'b1;
      if (reg_we && reg_addr == 2'(REG_BASE)) base_q <= ADDR_W'(reg_wdata);
      if (reg_we && reg_addr == 2'(REG_PTR))  wr_q <= reg_wdata[PTR_W-1:0];
      case (reg_addr)
        2'(REG_BASE): rdata_q <= 32'(base_q);
        2'(REG_PTR):  rdata_q <= (32'(rd_q) << 16) | 32'(wr_q);
        2'(REG_STAT): rdata_q <= 32'(status_q);
        default:      rdata_q <= 32'(status_q[ST_DRAINED] ? 1'b0 : 1'b0);
      endcase
    end
  end

  assign base      = base_q;
  assign rd_ptr    = rd_q;
  assign wr_ptr    = wr_q;
  assign irq       = irq_q;
  assign reg_rdata = rdata_q;

  AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_q != $past(rd_q)) |-> (rd_q == PTR_W'($past(rd_q) + 1'b1))); // R1
  AST_RD_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
    (rd_q != $past(rd_q)) |-> $past(rd_q != wr_q)); // R2
  AST_PTR_WRITE_KEEPS_RD: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'(REG_PTR) && !adv) |=> (rd_q == $past(rd_q))); // R9
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'(REG_STAT) && reg_wdata[ST_SENT] && !set_bits[ST_SENT])
      |=> !status_q[ST_SENT]); // R10
endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma
  import tx_ring_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PTR_W   = 6,
  parameter int MAX_LEN = 1700
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [PTR_W-1:0]  wr_ptr,
  output logic              adv,
  output logic [7:0]        set_bits,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam int LEN_W  = $clog2(MAX_LEN + 1);
  localparam int SEG_W  = 17;
  localparam int DESC_B = 128;
  localparam int DSH    = $clog2(DESC_B);

  dma_state_t        state;
  logic [ADDR_W-1:0] desc_q, addr_q, cur_q, desc_next, inline_addr;
  logic [15:0]       len_q;
  logic [2:0]        en_q;
  logic [1:0]        seg_q, nseg;
  logic [SEG_W-1:0]  seg_left_q, hdr_total;
  logic [LEN_W-1:0]  remain_q;
  logic [63:0]       wbuf_q;
  logic              err_q, over, more;
  logic [7:0]        set_q, txd_q;
  logic              txv_q, txl_q;
  logic              unused_rdata;

  function automatic logic [7:0] pick(input logic [63:0] w, input logic [2:0] k);
    return w[8*(7-k) +: 8];
  endfunction

  assign desc_next   = base + ADDR_W'({rd_ptr, {DSH{1'b0}}});
  assign inline_addr = desc_q + ADDR_W'(mem_rdata[22:16]);
  assign hdr_total   = SEG_W'(mem_rdata[15:0]) + 1'b1;
  assign over        = hdr_total > SEG_W'(MAX_LEN);
  assign nseg        = seg_q + 1'b1;
  assign more        = (seg_q != 2'd3) && en_q[nseg - 1'b1];
  assign unused_rdata = ^mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; desc_q <= '0; addr_q <= '0; cur_q <= '0;
      len_q <= '0; en_q <= '0; seg_q <= '0; seg_left_q <= '0;
      remain_q <= '0; wbuf_q <= '0; err_q <= 1'b0; set_q <= '0;
      txd_q <= '0; txv_q <= 1'b0; txl_q <= 1'b0;
    end else begin
      set_q <= '0;
      case (state)
        S_IDLE: if (base != '0 && rd_ptr != wr_ptr) begin
          desc_q <= desc_next;
          addr_q <= desc_next;
          state  <= S_HDR;
        end
        S_HDR: if (mem_ack) begin
          len_q <= mem_rdata[15:0];
          en_q  <= mem_rdata[27:25];
          if (mem_rdata[63]) state <= S_ADV;
          else if (mem_rdata[15:0] == 16'd0) state <= S_IDLE;
          else begin
            err_q      <= over;
            remain_q   <= over ? LEN_W'(MAX_LEN) : LEN_W'(hdr_total);
            seg_q      <= '0;
            cur_q      <= inline_addr;
            seg_left_q <= SEG_W'(DESC_B) - SEG_W'(mem_rdata[22:16]);
            addr_q     <= {inline_addr[ADDR_W-1:3], 3'b000};
            state      <= S_FETCH;
          end
        end
        S_PTR: if (mem_ack) begin
          cur_q      <= ADDR_W'({mem_rdata[31:3], 3'b000});
          addr_q     <= ADDR_W'({mem_rdata[31:3], 3'b000});
          seg_left_q <= SEG_W'(mem_rdata[47:32]) + 1'b1;
          state      <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          wbuf_q <= mem_rdata;
          txd_q  <= pick(mem_rdata, cur_q[2:0]);
          txl_q  <= (remain_q == LEN_W'(1));
          txv_q  <= 1'b1;
          state  <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          txv_q      <= 1'b0;
          cur_q      <= cur_q + 1'b1;
          remain_q   <= remain_q - 1'b1;
          seg_left_q <= seg_left_q - 1'b1;
          if (remain_q == LEN_W'(1)) begin
            addr_q <= desc_q;
            state  <= S_WB;
          end else if (seg_left_q == SEG_W'(1)) begin
            if (more) begin
              seg_q  <= nseg;
              addr_q <= desc_q + ADDR_W'({nseg, 3'b000});
              state  <= S_PTR;
            end else begin
              err_q  <= 1'b1;
              addr_q <= desc_q;
              state  <= S_WB;
            end
          end else if (cur_q[2:0] == 3'd7) begin
            addr_q <= cur_q + 1'b1;
            state  <= S_FETCH;
          end else begin
            txv_q <= 1'b1;
            txd_q <= pick(wbuf_q, cur_q[2:0] + 1'b1);
            txl_q <= (remain_q == LEN_W'(2));
          end
        end
        S_WB: if (mem_ack) begin
          set_q[ST_DRAINED] <= 1'b1;
          set_q[ST_SENT]    <= 1'b1;
          set_q[ST_LENERR]  <= err_q;
          state             <= S_ADV;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign adv       = (state == S_ADV);
  assign set_bits  = set_q;
  assign mem_req   = (state == S_HDR) || (state == S_PTR) || (state == S_FETCH) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_addr  = addr_q;
  assign mem_wdata = {8'h80, 32'h0, 8'h80, len_q};
  assign tx_valid  = txv_q;
  assign tx_data   = txd_q;
  assign tx_last   = txl_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R13
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R1
  AST_BASE_OFF: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && base == '0) |=> !mem_req); // R2
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid); // R5
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
  parameter int ADDR_W  = 32,
  parameter int PTR_W   = 6,
  parameter int MAX_LEN = 1700
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              irq
);
  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic              adv;
  logic [7:0]        set_bits;

  tx_ring_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adv(adv),
    .set_bits(set_bits), .base(base), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .irq(irq)
  );

  tx_ring_dma #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .MAX_LEN(MAX_LEN)) u_dma (
    .clk(clk), .rst(rst), .base(base), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .adv(adv), .set_bits(set_bits), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready)
  );
endmodule

// File: tb/tb_tx_ring_engine.sv
module tb_tx_ring_engine;
  localparam int BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack;
  logic [63:0] mem_rdata;
  logic        tx_valid, tx_last, tx_ready;
  logic [7:0]  tx_data;
  logic        irq;

  always #2 clk = ~clk;

  tx_ring_engine dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
  );

  bit [63:0]  mem [int];
  logic [7:0] exp_q [$];
  bit         last_q [$];
  int checks = 0, errors = 0, reqs = 0, wbs = 0, cyc = 0, ready_mode = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] get_byte(input int a);
    bit [63:0] w;
    w = mem.exists(a >> 3) ? mem[a >> 3] : 64'h0;
    return w[8*(7-(a & 7)) +: 8];
  endfunction

  task automatic set_byte(input int a, input logic [7:0] v);
    bit [63:0] w;
    w = mem.exists(a >> 3) ? mem[a >> 3] : 64'h0;
    w[8*(7-(a & 7)) +: 8] = v;
    mem[a >> 3] = w;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  // Memory responder and stream sink with byte-level reference comparison
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      mem_ack = 1'b0; mem_rdata = '0; tx_ready = 1'b0;
    end else begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        reqs++;
        if (mem_we) begin mem[int'(mem_addr >> 3)] = mem_wdata; wbs++; end
        else mem_rdata = mem.exists(int'(mem_addr >> 3)) ? mem[int'(mem_addr >> 3)] : 64'h0;
        mem_ack = 1'b1;
      end
      tx_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 5) != 2 && (cyc % 7) != 3);
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected stream byte", tx_data, 0);
        else begin
          logic [7:0] e;
          bit l;
          e = exp_q.pop_front();
          l = last_q.pop_front();
          chk(tx_data == e, "R5", "stream byte", tx_data, e);
          chk(tx_last == l, "R5", "tx_last flag", tx_last, l);
        end
      end
    end
  end

  // Builds descriptor idx and, when push is set, the expected byte sequence
  task automatic build(input int idx, input int raw, input int off, input int en,
                       input int pa1, input int pl1, input int pa2, input int pl2,
                       input bit push);
    int d, total, n;
    int pa[3];
    int pl[3];
    d = BASE + idx * 128;
    pa[1] = pa1; pl[1] = pl1; pa[2] = pa2; pl[2] = pl2;
    for (int k = 0; k < 128; k++) set_byte(d + k, pat(d + k));
    for (int p = 1; p < 3; p++)
      if (en & (1 << p))
        for (int k = 0; k <= pl[p]; k++) set_byte((pa[p] & ~7) + k, pat((pa[p] & ~7) + k));
    for (int k = 0; k < 4; k++) set_byte(d + k, 8'h00);
    set_byte(d + 4, 8'(en));
    set_byte(d + 5, 8'(off));
    set_byte(d + 6, 8'(raw >> 8));
    set_byte(d + 7, 8'(raw));
    for (int p = 1; p < 3; p++)
      if (en & (1 << p)) begin
        set_byte(d + 8*p,     8'h00);
        set_byte(d + 8*p + 1, 8'h00);
        set_byte(d + 8*p + 2, 8'(pl[p] >> 8));
        set_byte(d + 8*p + 3, 8'(pl[p]));
        for (int k = 0; k < 4; k++) set_byte(d + 8*p + 4 + k, 8'(pa[p] >> (24 - 8*k)));
      end
    if (push) begin
      total = (raw + 1 > 1700) ? 1700 : raw + 1;
      n = 0;
      for (int a = off; a < 128 && n < total; a++) begin
        exp_q.push_back(get_byte(d + a)); last_q.push_back(1'b0); n++;
      end
      for (int p = 1; p < 3; p++)
        if (en & (1 << p))
          for (int k = 0; k <= pl[p] && n < total; k++) begin
            exp_q.push_back(get_byte((pa[p] & ~7) + k)); last_q.push_back(1'b0); n++;
          end
      if (n == total) last_q[last_q.size() - 1] = 1'b1;
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_rd(input int target);
    logic [31:0] v;
    for (int i = 0; i < 30000; i++) begin
      reg_read(2'd1, v);
      if (int'(v[21:16]) == target) break;
    end
  endtask

  function automatic bit [63:0] done_word(input logic [15:0] len);
    return {8'h80, 32'h0, 8'h80, len};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit [63:0] d1_before;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R9", "tx_valid after reset", tx_valid, 0);
    chk(irq == 1'b0, "R12", "irq after reset", irq, 0);
    chk(mem_req == 1'b0, "R2", "mem_req after reset", mem_req, 0);
    for (int r = 0; r < 4; r++) begin
      reg_read(2'(r), v);
      chk(v == 32'h0, "R9", "register reset value", v, 0);
    end

    // Zero base: engine must stay off the memory bus
    reg_write(2'd1, 32'd3);
    repeat (40) @(negedge clk);
    chk(reqs == 0, "R2", "requests with zero base", reqs, 0);
    reg_read(2'd1, v);
    chk(v == 32'h0000_0003, "R2", "pointers with zero base", v, 32'h3);

    // Ring contents
    build(0, 19, 40, 0, 0, 0, 0, 0, 1'b1);
    build(1, 5, 16, 0, 0, 0, 0, 0, 1'b0);
    set_byte(BASE + 128, 8'h80);
    d1_before = mem[(BASE + 128) >> 3];
    build(2, 22, 120, 6, 32'h0004_0003, 9, 32'h0004_0100, 4, 1'b1);
    build(3, 1999, 0, 2, 32'h0004_1000, 1999, 0, 0, 1'b1);
    build(4, 0, 32, 0, 0, 0, 0, 0, 1'b0);

    ready_mode = 1;
    reg_write(2'd1, 32'd5);
    reg_write(2'd0, BASE);
    wait_rd(4);
    repeat (100) @(negedge clk);
    reg_read(2'd1, v);
    chk(v[21:16] == 6'd4, "R4", "read index held on empty descriptor", v[21:16], 4);
    chk(exp_q.size() == 0, "R5", "bytes outstanding", exp_q.size(), 0);
    chk(wbs == 3, "R3", "write-back count", wbs, 3);
    chk(mem[BASE >> 3] == done_word(16'd19), "R8", "completion word d0", mem[BASE >> 3], done_word(16'd19));
    chk(mem[(BASE + 128) >> 3] == d1_before, "R3", "skipped descriptor untouched", mem[(BASE + 128) >> 3], d1_before);
    chk(mem[(BASE + 256) >> 3] == done_word(16'd22), "R8", "completion word d2", mem[(BASE + 256) >> 3], done_word(16'd22));
    chk(mem[(BASE + 384) >> 3] == done_word(16'd1999), "R7", "completion word d3", mem[(BASE + 384) >> 3], done_word(16'd1999));
    reg_read(2'd2, v);
    chk(v == 32'h07, "R7", "status after truncation", v, 32'h07);
    chk(irq == 1'b1, "R12", "irq with status set", irq, 1);

    // Pointer register: read field is not writable
    reg_write(2'd1, 32'h003F_0005);
    reg_read(2'd1, v);
    chk(v == 32'h0004_0005, "R9", "pointer write ignores read field", v, 32'h0004_0005);

    reg_write(2'd2, 32'h02);
    reg_read(2'd2, v);
    chk(v == 32'h05, "R10", "write-one-to-clear bit 1", v, 32'h05);
    reg_write(2'd3, 32'h01);
    reg_read(2'd2, v);
    chk(v == 32'h05, "R11", "control enable keeps status", v, 32'h05);
    reg_write(2'd3, 32'h00);
    reg_read(2'd2, v);
    chk(v == 32'h04, "R11", "control disable clears bit 0", v, 32'h04);
    reg_write(2'd2, 32'h04);
    repeat (3) @(negedge clk);
    reg_read(2'd2, v);
    chk(v == 32'h00, "R10", "status cleared", v, 0);
    chk(irq == 1'b0, "R12", "irq after clear", irq, 0);

    // Short chain at 4, then skip 5..63 and wrap to 2
    for (int i = 5; i < 64; i++) set_byte(BASE + i * 128, 8'h80);
    build(4, 39, 100, 0, 0, 0, 0, 0, 1'b1);
    wait_rd(5);
    reg_write(2'd1, 32'd2);
    wait_rd(2);
    repeat (50) @(negedge clk);
    reg_read(2'd1, v);
    chk(v == 32'h0002_0002, "R1", "read index wrapped", v, 32'h0002_0002);
    chk(exp_q.size() == 0, "R6", "short chain bytes outstanding", exp_q.size(), 0);
    chk(wbs == 4, "R6", "write-back count after short chain", wbs, 4);
    reg_read(2'd2, v);
    chk(v == 32'h07, "R6", "short chain sets length error", v, 32'h07);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule